// File: doc/BRIEF.md
# Read Output Pipeline with Selectable Latency

This block sits between the storage array of a synchronous memory and its data pins. It accepts a per-cycle read request and a deselect command, and from them produces the output data word and a drive-enable for the pin drivers. A static mode input picks between two timings. In flow-through timing, the word coming from the array is passed straight to the output. In pipelined timing, the word is first captured in a rising-edge output register, which adds one cycle of latency.

Deselect commands go through exactly as many register stages as reads do. The drivers therefore let go of the bus on a dual-cycle-deselect schedule: after a deselect, they keep driving for one more full cycle. An asynchronous output-enable input gates the drive-enable directly and is never sampled by the clock. When a cycle carries neither a read nor a deselect, the output keeps its previous drive state and its last data word. This is how a burst is suspended.

The array is modelled as a fixed number of register stages, `ARRAY_LAT`. The word for a read sampled at clock edge k is present on `rd_data` during the cycle after edge k+`ARRAY_LAT`. With the default of 1, this gives the following first-access latencies, counting the edge that samples the command as edge 1:
- flow-through: 2 edges
- pipelined: 3 edges

Each following beat of a back-to-back burst then takes one edge.

Top module: `rdo_pipe`

## Requirements
- R1: While reset is asserted and just after it is released, `drive_en` is 0, and every stage holds the deselected state.
- R2: Flow-through (`pipe_mode`=0). A read sampled at edge k makes `drive_en`=1 during the cycle after edge k+1, and in that same cycle `dout` equals the current `rd_data`.
- R3: Pipelined (`pipe_mode`=1). A read sampled at edge k makes `drive_en`=1 and `dout` equal to the `rd_data` value sampled at edge k+2, during the cycle after edge k+2. Within that cycle, `dout` does not follow changes on `rd_data`.
- R4: Reads on consecutive edges each return their own word on consecutive cycles, one beat per clock, in issue order.
- R5: Pipelined. A deselect sampled at edge k leaves `drive_en` unchanged through the cycle after edge k+1. `drive_en` is 0 from just after edge k+2.
- R6: Flow-through. A deselect sampled at edge k gives `drive_en`=0 from just after edge k+1.
- R7: A read sampled on the edge right after a deselect returns valid data, with `drive_en`=1, at its normal latency. The deselect adds no extra delay.
- R8: `oe`=0 forces `drive_en` to 0 at once, without a clock edge. Raising `oe` again restores the pipelined drive state, also without an edge.
- R9: A cycle with neither a read nor a deselect leaves the drive state and `dout` as they were. In such cycles `rd_data` has no effect on `dout`.
- R10: When a read and a deselect are both asserted on the same edge, the deselect wins: no data is returned and the drive is released.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | Static mode: 1 selects pipelined timing, 0 selects flow-through |
| rd_req | input | 1 | Read command for this cycle |
| desel | input | 1 | Deselect command for this cycle (wins over `rd_req`) |
| rd_data | input | DATA_W | Word delivered by the array |
| oe | input | 1 | Asynchronous output enable, active high |
| dout | output | DATA_W | Output data word |
| drive_en | output | 1 | Pin driver enable |

## Verification
The hardest case to reach from the ports is a deselect directly followed by a read, in both modes. This is where the extra deselect stage must release the drive for exactly one cycle without delaying the next word. The stimulus issues deselect and read commands on adjacent edges, and also a read and a deselect on the same edge. It does so only after a burst has left the drive on, so that both the release and the restart are visible. The array model feeds fresh words only in the cycles where the data for a read is due, and garbage otherwise. In pipelined mode, `rd_data` is also scrambled in the middle of a cycle. Any leak from the wrong cycle, or any bypass of the output register, therefore shows up on `dout`.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

   // One pipeline slot: act = drivers should be on, fresh = a new word is due
   typedef struct packed {
      logic act;
      logic fresh;
   } rdo_slot_t;

   localparam rdo_slot_t RDO_OFF = '{act: 1'b0, fresh: 1'b0};

   // Command acceptance: deselect beats read; no command holds the drive state
   function automatic rdo_slot_t rdo_accept(input rdo_slot_t cur,
                                            input logic rd,
                                            input logic ds);
      rdo_slot_t nxt;
      nxt.fresh = rd & ~ds;
      if (ds)
         nxt.act = 1'b0;
      else if (rd)
         nxt.act = 1'b1;
      else
         nxt.act = cur.act;
      return nxt;
   endfunction

endpackage

// File: rtl/rdo_cmd_stage.sv
module rdo_cmd_stage
   import rdo_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rd_req,
   input  logic      desel,
   output rdo_slot_t slot_o
);

   rdo_slot_t slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot_q <= RDO_OFF;
      else
         slot_q <= rdo_accept(slot_q, rd_req, desel);
   end

   assign slot_o = slot_q;

endmodule

// File: rtl/rdo_shift_stage.sv
module rdo_shift_stage
   import rdo_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  rdo_slot_t slot_i,
   output rdo_slot_t slot_o
);

   rdo_slot_t slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot_q <= RDO_OFF;
      else
         slot_q <= slot_i;
   end

   assign slot_o = slot_q;

endmodule

// File: rtl/rdo_data_path.sv
module rdo_data_path #(
   parameter int DATA_W     = 36,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              load,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] word_q;

   // Output register: captures each word on the edge that ends its array cycle
   generate
      if (RESET_DATA) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= '0;
            else if (load)
               word_q <= rd_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (load)
               word_q <= rd_data;
         end
      end
   endgenerate

   // Flow-through bypasses the register only while a fresh word is present
   always_comb begin
      if (!pipe_mode && load)
         dout = rd_data;
      else
         dout = word_q;
   end

endmodule

// File: rtl/rdo_pipe.sv
module rdo_pipe
   import rdo_pkg::*;
#(
   parameter int DATA_W     = 36,
   parameter int ARRAY_LAT  = 1,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_mode,
   input  logic              rd_req,
   input  logic              desel,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              oe,
   output logic [DATA_W-1:0] dout,
   output logic              drive_en
);

   localparam int TAP = ARRAY_LAT;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("rdo_pipe: DATA_W must be at least 1");
      end
      if (ARRAY_LAT < 1 || ARRAY_LAT > 8) begin : g_bad_lat
         $error("rdo_pipe: ARRAY_LAT must lie in 1..8");
      end
   endgenerate

   rdo_slot_t chain [0:TAP];
   rdo_slot_t out_slot;
   logic      drive_state;

   rdo_cmd_stage u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_req (rd_req),
      .desel  (desel),
      .slot_o (chain[0])
   );

   // Array access stages: reads and deselects advance together
   generate
      for (genvar i = 1; i <= TAP; i++) begin : g_arr
         rdo_shift_stage u_stg (
            .clk    (clk),
            .rst_n  (rst_n),
            .slot_i (chain[i-1]),
            .slot_o (chain[i])
         );
      end
   endgenerate

   // Output register stage, used in pipelined timing
   rdo_shift_stage u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .slot_i (chain[TAP]),
      .slot_o (out_slot)
   );

   rdo_data_path #(
      .DATA_W     (DATA_W),
      .RESET_DATA (RESET_DATA)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .load      (chain[TAP].fresh),
      .rd_data   (rd_data),
      .dout      (dout)
   );

   assign drive_state = pipe_mode ? out_slot.act : chain[TAP].act;
   assign drive_en    = drive_state & oe;

endmodule

// File: rtl/rdo_pipe_chk.sv
module rdo_pipe_chk #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pipe_mode,
   input logic              rd_req,
   input logic              desel,
   input logic [DATA_W-1:0] rd_data,
   input logic              oe,
   input logic [DATA_W-1:0] dout,
   input logic              drive_en
);

   // R1: drive is off on the first edge after reset release
   p_quiet_after_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !drive_en);

   // R2: flow-through word shows two edges after the read
   p_flow_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && $past(rd_req && !desel, 2) && oe) |-> (drive_en && dout == rd_data));

   // R3: pipelined word is the one sampled on the previous edge
   p_pipe_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && $past(rd_req && !desel, 3) && oe) |-> (drive_en && dout == $past(rd_data, 1)));

   // R5: pipelined drive released three edges after a deselect
   p_pipe_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_mode && $past(desel, 3)) |-> !drive_en);

   // R6: flow-through drive released two edges after a deselect
   p_flow_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pipe_mode && $past(desel, 2)) |-> !drive_en);

   // R8: output enable low always wins
   p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !drive_en);

endmodule

bind rdo_pipe rdo_pipe_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pipe_mode (pipe_mode),
   .rd_req    (rd_req),
   .desel     (desel),
   .rd_data   (rd_data),
   .oe        (oe),
   .dout      (dout),
   .drive_en  (drive_en)
);

// File: tb/rdo_pipe_test.sv
module rdo_pipe_test;

   localparam int CLK_P = 20;
   localparam int DW    = 36;

   typedef struct {
      logic          act;
      logic [DW-1:0] data;
      int            req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pipe_mode = 1'b0;
   logic          rd_req = 1'b0;
   logic          desel = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          oe = 1'b1;
   logic [DW-1:0] dout;
   logic          drive_en;

   int n_cmp = 0;
   int n_bad = 0;

   exp_t          exp_q[$];
   logic          eff_act;
   logic [DW-1:0] eff_data;
   logic          p1_fresh, p2_fresh;
   logic [DW-1:0] p1_data, p2_data;
   logic          last_act;
   event          sample_ev;

   always #(CLK_P/2) clk = ~clk;

   rdo_pipe #(.DATA_W(DW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_mode (pipe_mode),
      .rd_req    (rd_req),
      .desel     (desel),
      .rd_data   (rd_data),
      .oe        (oe),
      .dout      (dout),
      .drive_en  (drive_en)
   );

   function automatic string tag(input int r);
      case (r)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input bit ok, input int r, input string what,
                        input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag(r), what, act_v, exp_v, $time);
      end
   endtask

   // Monitor: pops the expected item due in this cycle
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() == 0) begin
            check(1'b0, 1, "scoreboard empty", '0, '1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            last_act = e.act;
            check(drive_en == e.act, e.req, "drive_en", DW'(drive_en), DW'(e.act));
            if (e.act)
               check(dout == e.data, e.req, "dout", dout, e.data);
         end
      end
   end

   // Driver: one command per clock, array word for the read two edges back
   task automatic step(input logic rd, input logic ds, input int r, input bit oe_probe);
      logic [DW-1:0] word;
      logic [DW-1:0] held;
      logic          fresh;
      exp_t          e;
      @(negedge clk);
      word    = DW'({$urandom(), $urandom()});
      rd_data = p2_fresh ? p2_data : DW'({$urandom(), $urandom()});
      rd_req  = rd;
      desel   = ds;
      fresh   = rd & ~ds;
      if (ds)
         eff_act = 1'b0;
      else if (rd)
         eff_act = 1'b1;
      if (fresh)
         eff_data = word;
      e.act  = eff_act;
      e.data = eff_data;
      e.req  = r;
      exp_q.push_back(e);
      p2_fresh = p1_fresh;
      p2_data  = p1_data;
      p1_fresh = fresh;
      p1_data  = word;
      #2 -> sample_ev;
      #2;
      if (pipe_mode) begin
         held    = dout;
         rd_data = ~rd_data;
         #1 check(dout == held, 3, "dout moved with rd_data", dout, held);
         rd_data = ~rd_data;
      end else begin
         #1;
      end
      if (oe_probe) begin
         oe = 1'b0;
         #1 check(drive_en == 1'b0, 8, "drive_en with oe low", DW'(drive_en), '0);
         oe = 1'b1;
         #1 check(drive_en == last_act, 8, "drive_en after oe high", DW'(drive_en), DW'(last_act));
      end
   endtask

   task automatic do_reset(input logic pm);
      exp_t e;
      @(negedge clk);
      rst_n     = 1'b0;
      pipe_mode = pm;
      rd_req    = 1'b0;
      desel     = 1'b0;
      repeat (4) @(negedge clk);
      check(drive_en == 1'b0, 1, "drive_en in reset", DW'(drive_en), '0);
      exp_q.delete();
      for (int i = 0; i < (pm ? 3 : 2); i++) begin
         e.act  = 1'b0;
         e.data = '0;
         e.req  = 1;
         exp_q.push_back(e);
      end
      eff_act  = 1'b0;
      eff_data = '0;
      p1_fresh = 1'b0;
      p2_fresh = 1'b0;
      p1_data  = '0;
      p2_data  = '0;
      rst_n    = 1'b1;
   endtask

   task automatic run_phase(input logic pm);
      int rd_tag;
      int ds_tag;
      rd_tag = pm ? 3 : 2;
      ds_tag = pm ? 5 : 6;
      do_reset(pm);
      // first access and burst
      step(1, 0, rd_tag, 0);
      step(1, 0, 4, 0);
      step(1, 0, 4, 0);
      step(1, 0, 4, 0);
      // suspend: hold state, oe probe while driving
      step(0, 0, 9, 1);
      step(0, 0, 9, 0);
      // deselect then read at once
      step(0, 1, ds_tag, 0);
      step(1, 0, 7, 0);
      step(1, 0, 7, 0);
      // deselect then idle: stays released
      step(0, 1, ds_tag, 0);
      step(0, 0, 9, 1);
      step(0, 0, 9, 0);
      // read, then simultaneous read and deselect
      step(1, 0, rd_tag, 0);
      step(1, 1, 10, 0);
      step(0, 0, 10, 0);
      step(1, 0, 7, 0);
      step(0, 1, ds_tag, 0);
      step(1, 0, 7, 0);
      repeat (4) step(0, 0, 9, 0);
   endtask

   initial begin
      #(CLK_P * 20000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      last_act = 1'b0;
      repeat (2) @(negedge clk);
      run_phase(1'b0);
      run_phase(1'b1);
      run_phase(1'b0);
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule